// File: doc/BRIEF.md
# Configuration Pointer Chain Loader

This block brings a DMA-style network controller out of reset by walking a two-level pointer chain in memory. Once reset has been released, the first channel-attention pulse starts a fixed sequence of accesses on a word-wide bus-master port. The sequence first reads two words of a configuration pointer at a fixed start address. Those words give a system-bus configuration byte and the address of an intermediate pointer. The block then reads the two words of the intermediate pointer and forms the control-block address.

The addressing mode on `mode_i` is captured when the sequence starts, and it decides how the intermediate pointer is decoded:

- In the two segmented modes, a 16-bit offset is added to a separate base. The base is also presented as the common base for all later descriptors.
- In linear mode, a full 32-bit physical address is taken as it is.

After the address has been read, the block writes back a cleared busy byte without touching the other bytes of that word. It then pulses `init_done` for one cycle. Further channel-attention pulses have no effect until the next reset.

Top module: `cfg_chain_loader`

## Requirements
- R1: A sequence starts only on a `ca` high cycle while idle and armed. Reset arms the block, and starting a sequence disarms it. With no `ca` there is no memory request, and a `ca` after completion starts no new access until the next reset.
- R2: The accesses occur in this order: read at B, read at B+4, read at P, read at P+4, and write at P. B is the configuration start address and P is the word read at B+4. Each request holds `mem_req`, `mem_we` and `mem_addr` steady until a clock edge where `mem_rdy` is high.
- R3: B is the parameter `RESET_ADDR`, unless `alt_cfg_en` is high in the last cycle of reset. In that case B is the value of `alt_cfg_addr` in that cycle.
- R4: `sysbus_byte` equals bits 7:0 of the word read at B. `throttle_ext` is bit 3 of that word, `lock_en` is bit 4, and `irq_active_low` is bit 5.
- R5: Mode 2'b00 is legacy segmented. The base is the word at P+4 with bits 31:24 forced to zero. `cb_addr` is base plus bits 31:16 of the word at P, and `cmn_base` is the base.
- R6: Mode 2'b01 is full segmented. The base is the whole word at P+4, `cb_addr` is base plus bits 31:16 of the word at P, and `cmn_base` is the base.
- R7: Modes 2'b10 and 2'b11 are linear. `cb_addr` is the word at P+4 and `cmn_base` is zero.
- R8: The write at P comes only after all four reads. Its data has bits 7:0 zero and its byte enable is 4'b0001 (bit i enables byte i), so bits 31:8 of the word at P are left unchanged in memory.
- R9: `init_done` is high for exactly one cycle, the cycle after the write handshake. All configuration outputs are valid from that cycle on.
- R10: A `ca` pulse while the sequence runs is ignored: it adds no access and does not restart the sequence.
- R11: The mode is sampled in the cycle `ca` starts the sequence. Changes on `mode_i` later in the sequence do not alter the decoded addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; arms the sequencer |
| ca | input | 1 | Channel-attention pulse |
| mode_i | input | 2 | Addressing mode, sampled at start |
| alt_cfg_en | input | 1 | Selects the alternative configuration start address during reset |
| alt_cfg_addr | input | ADDR_W | Alternative configuration start address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | DATA_W | Write data |
| mem_be | output | DATA_W/8 | Byte enables for writes |
| mem_rdata | input | DATA_W | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Access completes at this edge |
| sysbus_byte | output | 8 | Latched system-bus configuration byte |
| throttle_ext | output | 1 | Bus-throttle timer triggered externally |
| lock_en | output | 1 | Locked bus cycles enabled |
| irq_active_low | output | 1 | Interrupt polarity is active low |
| cb_addr | output | ADDR_W | Control-block address |
| cmn_base | output | ADDR_W | Common descriptor base (zero in linear mode) |
| init_done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at five corner cases:

- **Busy-word write.** Memory keeps the upper 24 bits of the busy word. A design that writes a whole zero word would wipe the offset there.
- **Legacy-mode base.** The base is loaded with nonzero top bits. A design that ignores the mode would return them unchanged.
- **Linear mode.** A design that adds the offset in linear mode would shift `cb_addr`.
- **Extra channel attention.** A `ca` pulse is sent mid-sequence and again after completion. A design that restarts on it would lengthen the access trace.
- **Mode change mid-run.** `mode_i` is changed after the start. A design without a captured copy of the mode would decode with the wrong mode.

Memory ready delays are random to expose any access that does not hold its request steady, and runs with the alternative start address catch a wrong sampling of B.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CFG0,
      ST_CFG1,
      ST_PTR0,
      ST_PTR1,
      ST_CLEAR,
      ST_DONE
   } seq_state_t;

   typedef enum logic [1:0] {
      AM_LEGACY   = 2'b00,
      AM_SEG32    = 2'b01,
      AM_LINEAR   = 2'b10,
      AM_LINEAR_B = 2'b11
   } addr_mode_t;

   localparam int SB_TRIG_BIT = 3;
   localparam int SB_LOCK_BIT = 4;
   localparam int SB_IRQ_BIT  = 5;

endpackage

// File: rtl/ccl_seq.sv
module ccl_seq
   import cfg_chain_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ca,
   input  logic              mem_rdy,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] ptr_base,
   output seq_state_t        state,
   output logic              start,
   output logic              xfer,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   seq_state_t nxt;
   logic       armed;

   always_comb begin
      start   = (state == ST_IDLE) && armed && ca;
      mem_req = (state == ST_CFG0) || (state == ST_CFG1) || (state == ST_PTR0) ||
                (state == ST_PTR1) || (state == ST_CLEAR);
      mem_we  = (state == ST_CLEAR);
      xfer    = mem_req && mem_rdy;
   end

   always_comb begin
      case (state)
         ST_CFG0: mem_addr = cfg_base;
         ST_CFG1: mem_addr = cfg_base + STEP;
         ST_PTR1: mem_addr = ptr_base + STEP;
         default: mem_addr = ptr_base;
      endcase
   end

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:  if (start) nxt = ST_CFG0;
         ST_CFG0:  if (xfer)  nxt = ST_CFG1;
         ST_CFG1:  if (xfer)  nxt = ST_PTR0;
         ST_PTR0:  if (xfer)  nxt = ST_PTR1;
         ST_PTR1:  if (xfer)  nxt = ST_CLEAR;
         ST_CLEAR: if (xfer)  nxt = ST_DONE;
         default:             nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         armed <= 1'b1;
      end else begin
         state <= nxt;
         if (start) armed <= 1'b0;
      end
   end

endmodule

// File: rtl/ccl_addr_calc.sv
module ccl_addr_calc
   import cfg_chain_pkg::*;
#(
   parameter int ADDR_W           = 32,
   parameter int OFF_W            = 16,
   parameter int LEGACY_ZERO_BITS = 8
) (
   input  addr_mode_t        mode,
   input  logic [OFF_W-1:0]  offset,
   input  logic [ADDR_W-1:0] base_word,
   output logic [ADDR_W-1:0] cb_addr,
   output logic [ADDR_W-1:0] seg_base
);

   localparam logic [ADDR_W-1:0] LEGACY_MASK =
      {{LEGACY_ZERO_BITS{1'b0}}, {(ADDR_W-LEGACY_ZERO_BITS){1'b1}}};

   logic [ADDR_W-1:0] off_ext;

   assign off_ext = {{(ADDR_W-OFF_W){1'b0}}, offset};

   always_comb begin
      case (mode)
         AM_LEGACY: begin
            seg_base = base_word & LEGACY_MASK;
            cb_addr  = seg_base + off_ext;
         end
         AM_SEG32: begin
            seg_base = base_word;
            cb_addr  = seg_base + off_ext;
         end
         default: begin
            seg_base = '0;
            cb_addr  = base_word;
         end
      endcase
   end

endmodule

// File: rtl/ccl_busy_clear.sv
module ccl_busy_clear #(
   parameter int DATA_W       = 32,
   parameter int BUSY_W       = 8,
   parameter bit CLEAR_BY_RMW = 1'b0
) (
   input  logic [DATA_W-1:0]   ptr_w0,
   output logic [DATA_W-1:0]   wdata,
   output logic [DATA_W/8-1:0] be
);

   localparam int BE_W       = DATA_W / 8;
   localparam int BUSY_BYTES = BUSY_W / 8;

   assign wdata = {ptr_w0[DATA_W-1:BUSY_W], {BUSY_W{1'b0}}};

   generate
      if (CLEAR_BY_RMW) begin : g_rmw
         assign be = '1;
      end else begin : g_byte_en
         assign be = {{(BE_W-BUSY_BYTES){1'b0}}, {BUSY_BYTES{1'b1}}};
      end
   endgenerate

endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader
   import cfg_chain_pkg::*;
#(
   parameter int              ADDR_W       = 32,
   parameter int              DATA_W       = 32,
   parameter int              OFF_W        = 16,
   parameter int              BUSY_W       = 8,
   parameter logic [ADDR_W-1:0] RESET_ADDR = 32'hFFFF_FFF4,
   parameter bit              CLEAR_BY_RMW = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ca,
   input  logic [1:0]          mode_i,
   input  logic                alt_cfg_en,
   input  logic [ADDR_W-1:0]   alt_cfg_addr,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   output logic [DATA_W/8-1:0] mem_be,
   input  logic [DATA_W-1:0]   mem_rdata,
   input  logic                mem_rdy,
   output logic [7:0]          sysbus_byte,
   output logic                throttle_ext,
   output logic                lock_en,
   output logic                irq_active_low,
   output logic [ADDR_W-1:0]   cb_addr,
   output logic [ADDR_W-1:0]   cmn_base,
   output logic                init_done
);

   localparam int WORD_BYTES = DATA_W / 8;

   generate
      if (ADDR_W != DATA_W) begin : g_bad_width
         $error("cfg_chain_loader: ADDR_W must equal DATA_W");
      end
      if ((DATA_W % 8) != 0 || (BUSY_W % 8) != 0) begin : g_bad_bytes
         $error("cfg_chain_loader: DATA_W and BUSY_W must be byte multiples");
      end
      if (OFF_W + BUSY_W > DATA_W) begin : g_bad_offset
         $error("cfg_chain_loader: offset and busy fields overlap");
      end
   endgenerate

   seq_state_t        state;
   logic              start, xfer;
   logic [ADDR_W-1:0] cfg_base_q, ptr_q;
   logic [DATA_W-1:0] w0_q;
   addr_mode_t        mode_q;
   logic [ADDR_W-1:0] calc_cb, calc_base;

   ccl_seq #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_seq (
      .clk(clk), .rst(rst), .ca(ca), .mem_rdy(mem_rdy),
      .cfg_base(cfg_base_q), .ptr_base(ptr_q),
      .state(state), .start(start), .xfer(xfer),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr)
   );

   ccl_addr_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LEGACY_ZERO_BITS(8)) u_calc (
      .mode(mode_q), .offset(w0_q[DATA_W-1 -: OFF_W]),
      .base_word(mem_rdata[ADDR_W-1:0]),
      .cb_addr(calc_cb), .seg_base(calc_base)
   );

   ccl_busy_clear #(.DATA_W(DATA_W), .BUSY_W(BUSY_W), .CLEAR_BY_RMW(CLEAR_BY_RMW)) u_clear (
      .ptr_w0(w0_q), .wdata(mem_wdata), .be(mem_be)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_base_q  <= alt_cfg_en ? alt_cfg_addr : RESET_ADDR;
         mode_q      <= AM_LEGACY;
         sysbus_byte <= '0;
         ptr_q       <= '0;
         w0_q        <= '0;
         cb_addr     <= '0;
         cmn_base    <= '0;
      end else begin
         if (start) mode_q <= addr_mode_t'(mode_i);
         if (xfer) begin
            case (state)
               ST_CFG0: sysbus_byte <= mem_rdata[7:0];
               ST_CFG1: ptr_q       <= mem_rdata[ADDR_W-1:0];
               ST_PTR0: w0_q        <= mem_rdata;
               ST_PTR1: begin
                  cb_addr  <= calc_cb;
                  cmn_base <= calc_base;
               end
               default: ;
            endcase
         end
      end
   end

   assign throttle_ext   = sysbus_byte[SB_TRIG_BIT];
   assign lock_en        = sysbus_byte[SB_LOCK_BIT];
   assign irq_active_low = sysbus_byte[SB_IRQ_BIT];
   assign init_done      = (state == ST_DONE);

endmodule

// File: rtl/cfg_chain_loader_chk.sv
module cfg_chain_loader_chk
   import cfg_chain_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter bit CLEAR_BY_RMW = 1'b0
) (
   input logic                clk,
   input logic                rst,
   input addr_mode_t          mode_q,
   input logic                mem_req,
   input logic                mem_we,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [DATA_W/8-1:0] mem_be,
   input logic                mem_rdy,
   input logic                init_done,
   input logic [ADDR_W-1:0]   cmn_base
);

   logic [2:0] reads_done;
   logic       done_seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         reads_done <= '0;
         done_seen  <= 1'b0;
      end else begin
         if (mem_req && mem_rdy && !mem_we && reads_done != 3'd4)
            reads_done <= reads_done + 3'd1;
         if (init_done) done_seen <= 1'b1;
      end
   end

   assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
      mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   assert_write_last_R8: assert property (@(posedge clk) disable iff (rst)
      mem_req && mem_we |-> reads_done == 3'd4);

   assert_busy_be_R8: assert property (@(posedge clk) disable iff (rst)
      mem_req && mem_we |-> (CLEAR_BY_RMW ? (&mem_be) : (mem_be == 4'b0001)));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      init_done |=> !init_done);

   assert_single_init_R1: assert property (@(posedge clk) disable iff (rst)
      init_done |-> !done_seen);

   assert_legacy_base_R5: assert property (@(posedge clk) disable iff (rst)
      init_done && mode_q == AM_LEGACY |-> cmn_base[ADDR_W-1 -: 8] == 8'h00);

endmodule

bind cfg_chain_loader cfg_chain_loader_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLEAR_BY_RMW(CLEAR_BY_RMW)
) u_chk (
   .clk(clk), .rst(rst), .mode_q(mode_q), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_be(mem_be), .mem_rdy(mem_rdy),
   .init_done(init_done), .cmn_base(cmn_base)
);

// File: tb/cfg_chain_loader_bench.sv
module cfg_chain_loader_bench;

   localparam logic [31:0] RST_ADDR = 32'hFFFF_FFF4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ca = 1'b0;
   logic [1:0]  mode_i = 2'b00;
   logic        alt_cfg_en = 1'b0;
   logic [31:0] alt_cfg_addr = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic [31:0] mem_rdata = '0;
   logic        mem_rdy = 1'b0;
   logic [7:0]  sysbus_byte;
   logic        throttle_ext, lock_en, irq_active_low;
   logic [31:0] cb_addr, cmn_base;
   logic        init_done;

   int n_checks = 0;
   int n_fail = 0;

   logic [31:0] mem_model [logic [31:0]];
   logic [31:0] trace_addr [0:15];
   logic        trace_we [0:15];
   int          trace_n = 0;

   always #10 clk = ~clk;

   cfg_chain_loader u_cfg_chain_loader (
      .clk(clk), .rst(rst), .ca(ca), .mode_i(mode_i),
      .alt_cfg_en(alt_cfg_en), .alt_cfg_addr(alt_cfg_addr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
      .sysbus_byte(sysbus_byte), .throttle_ext(throttle_ext), .lock_en(lock_en),
      .irq_active_low(irq_active_low), .cb_addr(cb_addr), .cmn_base(cmn_base),
      .init_done(init_done)
   );

   // Memory responder: decides ready at the falling edge; the handshake
   // then completes at the following rising edge with the request held.
   always @(negedge clk) begin
      if (!rst && mem_req && ($urandom % 3 != 0)) begin
         logic [31:0] mask;
         mem_rdy = 1'b1;
         if (trace_n < 16) begin
            trace_addr[trace_n] = mem_addr;
            trace_we[trace_n]   = mem_we;
         end
         trace_n++;
         if (mem_we) begin
            mask = {{8{mem_be[3]}}, {8{mem_be[2]}}, {8{mem_be[1]}}, {8{mem_be[0]}}};
            mem_model[mem_addr] = (mem_model[mem_addr] & ~mask) | (mem_wdata & mask);
            mem_rdata = '0;
         end else begin
            mem_rdata = mem_model.exists(mem_addr) ? mem_model[mem_addr] : 32'h0;
         end
      end else begin
         mem_rdy   = 1'b0;
         mem_rdata = '0;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_base(input logic [1:0] m, input logic [31:0] w1);
      if (m == 2'b00) return w1 & 32'h00FF_FFFF;
      if (m == 2'b01) return w1;
      return 32'h0;
   endfunction

   function automatic logic [31:0] exp_cb(input logic [1:0] m, input logic [31:0] w0,
                                          input logic [31:0] w1);
      if (m[1]) return w1;
      return exp_base(m, w1) + {16'h0, w0[31:16]};
   endfunction

   task automatic run_init(input logic [1:0] m, input bit use_alt, input logic [31:0] alt,
                           input logic [31:0] cfg0, input logic [31:0] ptr,
                           input logic [31:0] w0, input logic [31:0] w1,
                           input bit extra_ca, input bit flip_mode);
      logic [31:0] b;
      int waited;
      bit got;
      b = use_alt ? alt : RST_ADDR;
      @(negedge clk);
      rst = 1'b1;
      alt_cfg_en = use_alt;
      alt_cfg_addr = alt;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      alt_cfg_en = ~use_alt;
      alt_cfg_addr = ~alt;
      trace_n = 0;
      mem_model.delete();
      mem_model[b] = cfg0;
      mem_model[b + 32'd4] = ptr;
      mem_model[ptr] = w0;
      mem_model[ptr + 32'd4] = w1;
      repeat (4) @(negedge clk);
      check(!mem_req && trace_n == 0 && !init_done, "R1 no start without ca",
            {31'h0, mem_req}, 32'h0);
      mode_i = m;
      ca = 1'b1;
      @(negedge clk);
      ca = 1'b0;
      if (flip_mode) mode_i = ~m;
      if (extra_ca) begin
         repeat (2) @(negedge clk);
         ca = 1'b1;
         @(negedge clk);
         ca = 1'b0;
      end
      got = 1'b0;
      waited = 0;
      while (!got && waited < 2000) begin
         if (init_done) got = 1'b1;
         else begin
            @(negedge clk);
            waited++;
         end
      end
      check(got, "R9 init_done seen", {31'h0, got}, 32'h1);
      if (!got) return;
      check(sysbus_byte == cfg0[7:0], "R4 sysbus byte", {24'h0, sysbus_byte}, {24'h0, cfg0[7:0]});
      check({throttle_ext, lock_en, irq_active_low} == {cfg0[3], cfg0[4], cfg0[5]},
            "R4 decoded flags", {29'h0, throttle_ext, lock_en, irq_active_low},
            {29'h0, cfg0[3], cfg0[4], cfg0[5]});
      check(cb_addr == exp_cb(m, w0, w1),
            m[1] ? "R7 linear cb_addr" : (m[0] ? "R6 seg32 cb_addr R11" : "R5 legacy cb_addr R11"),
            cb_addr, exp_cb(m, w0, w1));
      check(cmn_base == exp_base(m, w1),
            m[1] ? "R7 linear cmn_base" : (m[0] ? "R6 seg32 cmn_base" : "R5 legacy cmn_base"),
            cmn_base, exp_base(m, w1));
      check(mem_model[ptr] == {w0[31:8], 8'h00}, "R8 busy byte cleared, upper kept",
            mem_model[ptr], {w0[31:8], 8'h00});
      check(trace_n == 5, extra_ca ? "R10 access count with extra ca" : "R2 access count",
            trace_n, 32'd5);
      if (trace_n == 5) begin
         check(trace_addr[0] == b && !trace_we[0], "R3 R2 first read at start address",
               trace_addr[0], b);
         check(trace_addr[1] == b + 32'd4 && !trace_we[1], "R2 second read", trace_addr[1], b + 32'd4);
         check(trace_addr[2] == ptr && !trace_we[2], "R2 pointer word 0 read", trace_addr[2], ptr);
         check(trace_addr[3] == ptr + 32'd4 && !trace_we[3], "R2 pointer word 1 read",
               trace_addr[3], ptr + 32'd4);
         check(trace_addr[4] == ptr && trace_we[4], "R8 R2 clearing write last", trace_addr[4], ptr);
      end
      @(negedge clk);
      check(!init_done, "R9 init_done lasts one cycle", {31'h0, init_done}, 32'h0);
      ca = 1'b1;
      @(negedge clk);
      ca = 1'b0;
      repeat (20) @(negedge clk);
      check(trace_n == 5 && !mem_req && !init_done, "R1 ca after completion ignored",
            trace_n, 32'd5);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int seed_v;
      seed_v = $urandom(32'd715);
      repeat (3) @(negedge clk);
      check(!mem_req && !init_done && cb_addr == 32'h0, "R1 reset state",
            {31'h0, mem_req}, 32'h0);
      // directed corners
      run_init(2'b00, 1'b0, 32'h0, 32'h0000_0038, 32'h1000_0100, 32'hABCD_5501,
               32'hFF12_3450, 1'b0, 1'b0);
      run_init(2'b01, 1'b0, 32'h0, 32'h0000_0008, 32'h1000_0200, 32'hFFFF_7701,
               32'hFF12_3450, 1'b1, 1'b0);
      run_init(2'b10, 1'b1, 32'h2000_0040, 32'h0000_0010, 32'h1000_0300, 32'h1234_9901,
               32'hDEAD_BEE0, 1'b0, 1'b0);
      run_init(2'b11, 1'b1, 32'h2000_1000, 32'h0000_0020, 32'h1000_0400, 32'h0010_0001,
               32'h0000_1000, 1'b0, 1'b1);
      run_init(2'b00, 1'b0, 32'h0, 32'h0000_0000, 32'h1000_0500, 32'h8000_0001,
               32'hFFFF_FFF0, 1'b1, 1'b1);
      // constrained random
      for (int i = 0; i < 12; i++) begin
         logic [31:0] w0r, ptrr;
         w0r  = {$urandom, 8'h01} ;
         ptrr = 32'h1000_0000 | ($urandom & 32'h0FFF_FFF0);
         run_init(2'($urandom), 1'($urandom), 32'h2000_0000 | ($urandom & 32'h0000_FFF0),
                  $urandom, ptrr, w0r, $urandom, 1'($urandom), 1'($urandom));
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule